// File: doc/BRIEF.md
# NAND Host Bus Bridge

This block links a 16-bit host register bus to an 8-bit NAND flash device. The host sees a small register window: a data port, a packed control byte that sets the NAND pin states, a status byte with the device busy flag, and an interrupt status/mask pair. Every access to the data port becomes one or two NAND byte cycles. A 16-bit access is split into two sequential bytes, low byte first. An 8-bit access makes one byte cycle, which is how command and address bytes are sent.

Software first sets the pin state through the control byte: command latch, address latch or plain data, with chip enable asserted. It then moves bytes through the data port. For long operations it arms the ready interrupt. The interrupt fires when the device's ready/busy line goes from busy to ready.

The host bus takes a one-cycle request while `host_ready` is high. Register accesses complete with no wait. Data-port accesses hold `host_ready` low until the last NAND byte cycle has ended.

Top module: `nand_bus_bridge`

## Requirements
- R1: After reset: chip enable inactive (`nand_ce_n`=1), `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1, write protection applied (`nand_wp_n`=0), card power off, `irq`=0, `host_ready`=1, and the control byte at offset 4 reads 0x00.
- R2: The control byte at offset 4 reads back as written. Its pin mapping is: bit0 drives `nand_cle`, bit1 drives `nand_ale`, bit4 asserts chip enable (`nand_ce_n` low), and bit7 releases write protection (`nand_wp_n` high). Value 0x94 gives data mode, 0x95 command latch, 0x96 address latch, and 0x00 standby with chip enable off.
- R3: A control-byte write with bit3 set loads bit2 into the card power output, so 0x0C powers the card and 0x08 removes power. A write with bit3 clear leaves power unchanged.
- R4: A 16-bit write to offset 0 emits two NAND write strobes, the low byte first. Each strobe holds `nand_we_n` low for exactly STROBE_CYCLES clocks (default 2). CLE and ALE follow the control byte.
- R5: An 8-bit write to offset 0 emits exactly one NAND write strobe, which carries `host_wdata[7:0]`.
- R6: A 16-bit read from offset 0 makes two read strobes. The first byte returns in bits 7:0 and the second in bits 15:8. An 8-bit read makes one strobe and returns the byte in bits 7:0, with bits 15:8 zero.
- R7: After a data-port request is accepted, `host_ready` is low for exactly (STROBE_CYCLES+2) clocks per byte. Requests made while `host_ready` is low are ignored.
- R8: Status byte at offset 5: bit7 reads 1 while `nand_rb` shows busy (low), after a SYNC_STAGES-clock synchronizer. The other bits read 0.
- R9: A rising edge on `nand_rb` sets interrupt status bit0 (offset 6). A falling edge sets nothing.
- R10: A write to offset 6 clears each status bit written with a one and leaves bits written with a zero. Writing 0x0F clears all four.
- R11: The mask byte at offset 7 reads back as written. `irq` is high when mask bit7 is set and some status bit is set whose mask bit is also set. So 0x81 arms the ready interrupt, 0x01 and 0x00 hold it off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, taken while host_ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit data-port access, 0 = 8-bit |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data of the last completed read |
| host_ready | output | 1 | Bridge idle and ready for a request |
| nand_ce_n | output | 1 | NAND chip enable, active low |
| nand_cle | output | 1 | NAND command latch enable |
| nand_ale | output | 1 | NAND address latch enable |
| nand_we_n | output | 1 | NAND write strobe, active low |
| nand_re_n | output | 1 | NAND read strobe, active low |
| nand_wp_n | output | 1 | NAND write protect, active low |
| nand_pwr_en | output | 1 | Card power enable |
| nand_dq_out | output | 8 | NAND data bus, driven value |
| nand_dq_oe | output | 1 | NAND data bus output enable |
| nand_dq_in | input | 8 | NAND data bus, sampled value |
| nand_rb | input | 1 | NAND ready (1) / busy (0) |
| irq | output | 1 | Interrupt request |

## Verification
A byte index that is stuck or swapped shows up on the first 16-bit transfer, as bytes in the wrong order on the NAND pins or in the wrong half of the read word. A strobe counter that is off by one changes the low-pulse width and the host_ready window at once, so it is caught on the first byte cycle. A lost edge detector or a wrong synchronizer reset shows as status bit0 missing or spuriously set within a few clocks after `nand_rb` moves. A wrong mask gate shows as `irq` disagreeing with the register contents right after the write.

// File: rtl/nbb_pkg.sv
// Shared constants and types for the NAND host bus bridge.
// Assumes a 3-bit register offset and an 8-bit control byte.
package nbb_pkg;
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_CTRL = 3'd4;
    localparam logic [2:0] OFS_STAT = 3'd5;
    localparam logic [2:0] OFS_IST  = 3'd6;
    localparam logic [2:0] OFS_IMSK = 3'd7;

    localparam int CTRL_CLE    = 0;
    localparam int CTRL_ALE    = 1;
    localparam int CTRL_PWRVAL = 2;
    localparam int CTRL_PWRLD  = 3;
    localparam int CTRL_CE     = 4;
    localparam int CTRL_WPREL  = 7;

    localparam int IMSK_GLOBAL = 7;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_SETUP,
        CYC_STROBE,
        CYC_HOLD
    } cyc_state_e;
endpackage

// File: rtl/nbb_ctrl_reg.sv
// Control byte register: holds the packed pin-state byte and the card
// power latch. Assumes one write strobe per host write to the offset.
module nbb_ctrl_reg
    import nbb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] ctrl_q,
    output logic       ce_n,
    output logic       cle,
    output logic       ale,
    output logic       wp_n,
    output logic       pwr_en
);
    logic pwr_q;

    // Store the control byte on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= 8'h00;
        else if (wr_en)  ctrl_q <= wdata;
    end

    // Power latch is loaded only when the load bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                           pwr_q <= 1'b0;
        else if (wr_en && wdata[CTRL_PWRLD])  pwr_q <= wdata[CTRL_PWRVAL];
    end

    // Map stored bits onto the NAND pins.
    always_comb begin
        ce_n   = ~ctrl_q[CTRL_CE];
        cle    = ctrl_q[CTRL_CLE];
        ale    = ctrl_q[CTRL_ALE];
        wp_n   = ctrl_q[CTRL_WPREL];
        pwr_en = pwr_q;
    end

    // R3
    pwr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[CTRL_PWRLD]) |=> $stable(pwr_en));
endmodule

// File: rtl/nbb_irq_ctl.sv
// Ready/busy synchronizer, edge detector, interrupt status and mask.
// Assumes nand_rb is asynchronous; only source 0 has a hardware event.
module nbb_irq_ctl
    import nbb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_SRCS    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rb_in,
    input  logic                ist_clr_en,
    input  logic                imsk_wr_en,
    input  logic [7:0]          wdata,
    output logic                dev_busy,
    output logic [IRQ_SRCS-1:0] ist_q,
    output logic [7:0]          imsk_q,
    output logic                irq
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0]    rb_chain;
    logic                rb_rise;
    logic [IRQ_SRCS-1:0] src_evt;

    // Synchronize ready/busy; reset as "ready" so no edge follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rb_chain <= '1;
        else        rb_chain <= {rb_chain[CHAIN-2:0], rb_in};
    end

    assign rb_rise  = rb_chain[CHAIN-2] & ~rb_chain[CHAIN-1];
    assign dev_busy = ~rb_chain[CHAIN-2];

    // Event vector: source 0 is the ready edge, others have no event.
    generate
        for (genvar s = 0; s < IRQ_SRCS; s++) begin : g_src
            if (s == 0) begin : g_rdy
                assign src_evt[s] = rb_rise;
            end else begin : g_none
                assign src_evt[s] = 1'b0;
            end
        end
    endgenerate

    // Status bits: write-one-to-clear, a new event wins over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ist_q <= '0;
        else        ist_q <= (ist_q & ~(ist_clr_en ? wdata[IRQ_SRCS-1:0] : '0)) | src_evt;
    end

    // Mask byte store.
    always_ff @(posedge clk) begin
        if (!rst_n)          imsk_q <= 8'h00;
        else if (imsk_wr_en) imsk_q <= wdata;
    end

    // Request while globally enabled and any unmasked bit is set.
    assign irq = imsk_q[IMSK_GLOBAL] & (|(ist_q & imsk_q[IRQ_SRCS-1:0]));

    // R9
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rb_rise |=> ist_q[0]);
    // R10
    clr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ist_clr_en && wdata[0] && !rb_rise) |=> !ist_q[0]);
endmodule

// File: rtl/nbb_cycle_engine.sv
// NAND byte-cycle sequencer: setup, strobe low for STROBE_CYCLES, hold,
// once or twice per request. Assumes start only arrives while idle.
module nbb_cycle_engine
    import nbb_pkg::*;
#(
    parameter int STROBE_CYCLES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_wr,
    input  logic        start_wide,
    input  logic [15:0] wdata,
    input  logic [7:0]  dq_in,
    output logic        busy,
    output logic [15:0] rdata,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  dq_out,
    output logic        dq_oe
);
    localparam int CW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYCLES - 1);

    cyc_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          idx_q;
    logic          wr_q;
    logic          wide_q;
    logic [15:0]   wbuf_q;
    logic          strobe_end;

    assign strobe_end = (state_q == CYC_STROBE) && (cnt_q == CNT_LAST);

    // Sequence the phases of each byte cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            cnt_q   <= '0;
            idx_q   <= 1'b0;
        end else begin
            case (state_q)
                CYC_IDLE: begin
                    if (start) begin
                        state_q <= CYC_SETUP;
                        idx_q   <= 1'b0;
                    end
                end
                CYC_SETUP: begin
                    state_q <= CYC_STROBE;
                    cnt_q   <= '0;
                end
                CYC_STROBE: begin
                    if (strobe_end) state_q <= CYC_HOLD;
                    else            cnt_q   <= cnt_q + 1'b1;
                end
                CYC_HOLD: begin
                    if (wide_q && !idx_q) begin
                        idx_q   <= 1'b1;
                        state_q <= CYC_SETUP;
                    end else begin
                        state_q <= CYC_IDLE;
                    end
                end
                default: state_q <= CYC_IDLE;
            endcase
        end
    end

    // Capture the request attributes at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            wide_q <= 1'b0;
            wbuf_q <= '0;
        end else if (start && state_q == CYC_IDLE) begin
            wr_q   <= start_wr;
            wide_q <= start_wide;
            wbuf_q <= wdata;
        end
    end

    // Assemble read bytes: first into the low half, second into the high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (start && state_q == CYC_IDLE && !start_wr) begin
            rdata <= '0;
        end else if (strobe_end && !wr_q) begin
            if (idx_q) rdata[15:8] <= dq_in;
            else       rdata[7:0]  <= dq_in;
        end
    end

    // Pin outputs decoded from the phase registers.
    always_comb begin
        busy   = (state_q != CYC_IDLE);
        we_n   = !((state_q == CYC_STROBE) && wr_q);
        re_n   = !((state_q == CYC_STROBE) && !wr_q);
        dq_oe  = wr_q && (state_q != CYC_IDLE);
        dq_out = idx_q ? wbuf_q[15:8] : wbuf_q[7:0];
    end

    // Checker: length of each low strobe pulse.
    logic        strobe_low;
    logic [15:0] low_run_q;
    assign strobe_low = !we_n || !re_n;

    // Count consecutive low-strobe clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run_q <= '0;
        else if (strobe_low) low_run_q <= low_run_q + 1'b1;
        else                 low_run_q <= '0;
    end

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_low && $past(strobe_low)) |-> (low_run_q == 16'(STROBE_CYCLES)));
    // R4
    dq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CYC_STROBE) |-> $stable(dq_out));
    // R7
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (state_q == CYC_IDLE));
endmodule

// File: rtl/nand_bus_bridge.sv
// Top of the NAND host bus bridge: decodes host offsets, routes writes
// to the control, interrupt and data-port logic, and muxes read data.
// Assumes the host drives one request and waits for host_ready.
module nand_bus_bridge
    import nbb_pkg::*;
#(
    parameter int STROBE_CYCLES = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int IRQ_SRCS      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic        host_wide,
    input  logic [2:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_ready,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic        nand_wp_n,
    output logic        nand_pwr_en,
    output logic [7:0]  nand_dq_out,
    output logic        nand_dq_oe,
    input  logic [7:0]  nand_dq_in,
    input  logic        nand_rb,
    output logic        irq
);
    logic                accept;
    logic                eng_start;
    logic                ctrl_we;
    logic                ist_clr;
    logic                imsk_we;
    logic                eng_busy;
    logic [15:0]         eng_rdata;
    logic [7:0]          ctrl_q;
    logic                dev_busy;
    logic [IRQ_SRCS-1:0] ist_q;
    logic [7:0]          imsk_q;
    logic [7:0]          reg_byte;
    logic [7:0]          reg_rd_q;
    logic                rd_eng_q;

    // Decode the accepted request.
    always_comb begin
        accept    = host_req && host_ready;
        eng_start = accept && (host_addr == OFS_DATA);
        ctrl_we   = accept && host_wr && (host_addr == OFS_CTRL);
        ist_clr   = accept && host_wr && (host_addr == OFS_IST);
        imsk_we   = accept && host_wr && (host_addr == OFS_IMSK);
        host_ready = !eng_busy;
    end

    // Select the register byte for a read.
    always_comb begin
        case (host_addr)
            OFS_CTRL: reg_byte = ctrl_q;
            OFS_STAT: reg_byte = {dev_busy, 7'b0};
            OFS_IST:  reg_byte = 8'(ist_q);
            OFS_IMSK: reg_byte = imsk_q;
            default:  reg_byte = 8'h00;
        endcase
    end

    // Latch register read data and remember the read source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_q <= 8'h00;
            rd_eng_q <= 1'b0;
        end else if (accept && !host_wr) begin
            reg_rd_q <= reg_byte;
            rd_eng_q <= (host_addr == OFS_DATA);
        end
    end

    assign host_rdata = rd_eng_q ? eng_rdata : {8'h00, reg_rd_q};

    nbb_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_we),
        .wdata  (host_wdata[7:0]),
        .ctrl_q (ctrl_q),
        .ce_n   (nand_ce_n),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .wp_n   (nand_wp_n),
        .pwr_en (nand_pwr_en)
    );

    nbb_irq_ctl #(
        .SYNC_STAGES (SYNC_STAGES),
        .IRQ_SRCS    (IRQ_SRCS)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_in      (nand_rb),
        .ist_clr_en (ist_clr),
        .imsk_wr_en (imsk_we),
        .wdata      (host_wdata[7:0]),
        .dev_busy   (dev_busy),
        .ist_q      (ist_q),
        .imsk_q     (imsk_q),
        .irq        (irq)
    );

    nbb_cycle_engine #(
        .STROBE_CYCLES (STROBE_CYCLES)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (eng_start),
        .start_wr   (host_wr),
        .start_wide (host_wide),
        .wdata      (host_wdata),
        .dq_in      (nand_dq_in),
        .busy       (eng_busy),
        .rdata      (eng_rdata),
        .we_n       (nand_we_n),
        .re_n       (nand_re_n),
        .dq_out     (nand_dq_out),
        .dq_oe      (nand_dq_oe)
    );

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !host_ready);
    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
endmodule

// File: tb/nand_bus_bridge_tb_top.sv
`timescale 1ns/100ps
module nand_bus_bridge_tb_top;
    localparam int STROBE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_wide = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic [15:0] host_rdata;
    logic        host_ready;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
    logic        nand_wp_n, nand_pwr_en, nand_dq_oe, irq;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        nand_rb = 1'b1;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    logic [9:0] exp_q[$];
    logic [7:0] rd_q[$];

    always #2.5 clk = ~clk;

    nand_bus_bridge #(.STROBE_CYCLES(STROBE)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .nand_pwr_en(nand_pwr_en), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: NAND device model and scoreboard for write bytes.
    logic we_prev = 1'b1;
    logic re_prev = 1'b1;
    int   low_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n || !nand_re_n) low_run++;
            if (!we_prev && nand_we_n) begin
                wr_seen++;
                chk("R4 write strobe width", low_run, STROBE);
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected write byte", {nand_cle, nand_ale, nand_dq_out}, 10'h3ff);
                end else begin
                    chk("R4 write byte", {nand_cle, nand_ale, nand_dq_out}, exp_q.pop_front());
                end
            end
            if (!re_prev && nand_re_n) chk("R6 read strobe width", low_run, STROBE);
            if (!nand_re_n && re_prev) begin
                if (rd_q.size() != 0) nand_dq_in = rd_q.pop_front();
                else                  nand_dq_in = 8'hEE;
            end
            if (nand_we_n && nand_re_n) low_run = 0;
        end
        we_prev = nand_we_n;
        re_prev = nand_re_n;
    end

    task automatic host_xfer(input bit wr, input bit wide, input logic [2:0] addr,
                             input logic [15:0] wd, output logic [15:0] rd, output int busy_cyc);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_wide = wide; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        busy_cyc = 0;
        while (!host_ready) begin
            busy_cyc++;
            @(negedge clk);
        end
        rd = host_rdata;
    endtask

    task automatic reg_wr(input logic [2:0] addr, input logic [7:0] v);
        logic [15:0] rd; int bc;
        host_xfer(1'b1, 1'b0, addr, {8'h00, v}, rd, bc);
    endtask

    task automatic reg_rd(input logic [2:0] addr, output logic [15:0] rd);
        int bc;
        host_xfer(1'b0, 1'b0, addr, 16'h0, rd, bc);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int bc;
        int seen0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", nand_ce_n, 1);
        chk("R1 cle/ale", {nand_cle, nand_ale}, 0);
        chk("R1 we_n/re_n", {nand_we_n, nand_re_n}, 2'b11);
        chk("R1 wp_n", nand_wp_n, 0);
        chk("R1 power", nand_pwr_en, 0);
        chk("R1 irq", irq, 0);
        chk("R1 host_ready", host_ready, 1);
        reg_rd(3'd4, rd);
        chk("R1 ctrl reset value", rd, 16'h0000);

        // R3 power control
        reg_wr(3'd4, 8'h0C);
        chk("R3 power on", nand_pwr_en, 1);
        reg_wr(3'd4, 8'h94);
        chk("R3 power kept", nand_pwr_en, 1);
        // R2 data mode pins
        chk("R2 data mode pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n}, 4'b0001);
        reg_rd(3'd4, rd);
        chk("R2 ctrl readback", rd, 16'h0094);

        // R5 command byte
        reg_wr(3'd4, 8'h95);
        chk("R2 command mode cle", nand_cle, 1);
        seen0 = wr_seen;
        exp_q.push_back({2'b10, 8'h70});
        host_xfer(1'b1, 1'b0, 3'd0, 16'hAB70, rd, bc);
        @(negedge clk);
        chk("R5 single strobe", wr_seen - seen0, 1);
        chk("R7 8-bit busy cycles", bc, STROBE + 2);

        // R4 address bytes, low first
        reg_wr(3'd4, 8'h96);
        chk("R2 address mode ale", {nand_cle, nand_ale}, 2'b01);
        exp_q.push_back({2'b01, 8'h34});
        exp_q.push_back({2'b01, 8'h12});
        host_xfer(1'b1, 1'b1, 3'd0, 16'h1234, rd, bc);
        chk("R7 16-bit busy cycles", bc, 2 * (STROBE + 2));
        chk("R4 queue drained", exp_q.size(), 0);

        // R7 request during busy is ignored
        reg_wr(3'd4, 8'h94);
        exp_q.push_back({2'b00, 8'h5A});
        exp_q.push_back({2'b00, 8'hA5});
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_wide = 1'b1; host_addr = 3'd0; host_wdata = 16'hA55A;
        @(negedge clk);
        host_addr = 3'd4; host_wdata = 16'h0000;
        repeat (3) @(negedge clk);
        host_req = 1'b0;
        while (!host_ready) @(negedge clk);
        reg_rd(3'd4, rd);
        chk("R7 busy request ignored", rd, 16'h0094);
        chk("R4 queue drained 2", exp_q.size(), 0);

        // R6 reads
        rd_q.push_back(8'hC3);
        rd_q.push_back(8'h3C);
        host_xfer(1'b0, 1'b1, 3'd0, 16'h0, rd, bc);
        chk("R6 16-bit read order", rd, 16'h3CC3);
        rd_q.push_back(8'h5E);
        host_xfer(1'b0, 1'b0, 3'd0, 16'h0, rd, bc);
        chk("R6 8-bit read", rd, 16'h005E);

        // R8/R9 busy flag and edge
        nand_rb = 1'b0;
        repeat (5) @(negedge clk);
        reg_rd(3'd5, rd);
        chk("R8 status busy", rd, 16'h0080);
        reg_rd(3'd6, rd);
        chk("R9 falling edge no event", rd, 16'h0000);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        reg_rd(3'd5, rd);
        chk("R8 status ready", rd, 16'h0000);
        reg_rd(3'd6, rd);
        chk("R9 rising edge event", rd, 16'h0001);
        chk("R11 irq masked", irq, 0);

        // R11 mask
        reg_wr(3'd7, 8'h81);
        chk("R11 irq armed", irq, 1);
        reg_rd(3'd7, rd);
        chk("R11 mask readback", rd, 16'h0081);
        reg_wr(3'd7, 8'h01);
        chk("R11 global gate off", irq, 0);
        reg_wr(3'd7, 8'h81);
        chk("R11 rearmed", irq, 1);

        // R10 write-one-to-clear
        reg_wr(3'd6, 8'h0E);
        reg_rd(3'd6, rd);
        chk("R10 zero bit kept", rd, 16'h0001);
        reg_wr(3'd6, 8'h0F);
        reg_rd(3'd6, rd);
        chk("R10 cleared", rd, 16'h0000);
        chk("R11 irq drops", irq, 0);
        reg_wr(3'd7, 8'h00);

        // R3 power off, R2 standby
        reg_wr(3'd4, 8'h08);
        chk("R3 power off", nand_pwr_en, 0);
        reg_wr(3'd4, 8'h00);
        chk("R2 standby ce_n", nand_ce_n, 1);
        chk("R3 power stays off", nand_pwr_en, 0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule